// File: doc/BRIEF.md
# UART Host Register Bank with Prioritized Interrupt Identification

This block is the processor-facing side of a 16550-compatible serial port. A host issues single-cycle read or write strobes with a 3-bit offset. The block decodes them into the receive/transmit data port, interrupt enable, interrupt identification (read) / FIFO control (write), line control, modem control, line status, modem status and scratch registers. Line control bit 7 turns offsets 0 and 1 into the low and high bytes of the baud divisor. The block does not model serial timing. The transmitter always counts as ready, so a byte written to the data port is dropped unless loopback is on.

The receive FIFO is inside the block. It holds `DEPTH` bytes when FIFO mode is on and a single byte when it is off. It is filled either from a valid/ready receive stream or, in loopback, from host data writes. The stream follows these rules:
- A byte moves on every rising clock edge at which `rx_valid` and `rx_ready` are both high.
- `rx_ready` falls while the FIFO is full, which holds the sender back.
- In loopback, `rx_ready` stays high and accepted stream bytes are discarded.

A fixed-priority encoder turns four interrupt causes into an identification code and a single level-sensitive `irq`. Some reads have side effects: reading the identification register acknowledges a transmit-empty cause, reading line status clears overrun, and reading modem status clears its change bits.

Top module: `uart_regbank`

## Requirements
- R1: After reset the registers read as follows: divisor low 0x0C and high 0x00 (reference clock / baud / 16), IER 0x00, IIR 0x01, LCR 0x00, MCR 0x00, LSR 0x60, MSR 0xA0, scratch 0x00. `irq` is low and `rx_ready` is high.
- R2: While LCR bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. While LCR bit 7 is 0, those offsets reach the data port and the IER, and the divisor is untouched.
- R3: A write to IER (offset 1) keeps only bits 3:0. Bits 7:4 always read as 0.
- R4: Interrupt priority, highest first, with IIR bits 3:0:
  - overrun with IER bit 2 gives 0x6;
  - FIFO not empty with IER bit 0 gives 0x4;
  - transmit-empty pending with IER bit 1 gives 0x2;
  - any MSR change bit with IER bit 3 gives 0x0;
  - no active cause gives 0x1.
- R5: IIR (offset 2 read) bits 7:6 read as 11 while FIFO mode is enabled and 00 otherwise. Bits 5:4 read as 0.
- R6: A data-port write sets transmit-empty pending. An IIR read that reports code 0x2 clears it. An IIR read that reports any other code leaves it set.
- R7: A FIFO-control write (offset 2) with bit 0 clear stores all zeros. With bit 0 set it stores enable, DMA mode (bit 3) and trigger level (bits 7:6), which drive `dma_mode` and `rx_trig_lvl`. The FIFO is emptied when the enable bit changes, or when bit 0 and bit 1 are both set.
- R8: An LSR read returns bit 6 = 1, bit 5 = 1, bit 1 = overrun and bit 0 = FIFO not empty, with all other bits 0. Overrun is cleared after the read.
- R9: In loopback (MCR bit 4), a data-port write enters the FIFO. If the FIFO is full the byte is lost and overrun is set.
- R10: A data-port read returns and removes the oldest FIFO byte in arrival order. On an empty FIFO it returns 0xFF.
- R11: `rx_ready` is high in loopback or when the FIFO holds fewer bytes than its capacity (`DEPTH` in FIFO mode, 1 otherwise). Outside loopback an accepted stream byte enters the FIFO.
- R12: MCR keeps bits 4:0. MSR bits 7:4 (DCD, RI, DSR, CTS) are as follows:
  - in loopback they equal MCR bits 3, 2, 0, 1;
  - otherwise they read 1010.
  An MCR write sets MSR bit 0/1/3 when CTS/DSR/DCD changes, and bit 2 when RI falls. An MSR read clears bits 3:0 after returning them.
- R13: Scratch (offset 7) stores any byte. Writes to LSR and MSR change nothing.
- R14: `irq` is high exactly when the IIR code is not 0x1. It reflects the state after each access from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| rx_valid | input | 1 | Receive stream byte offered |
| rx_data | input | 8 | Receive stream byte |
| rx_ready | output | 1 | Receive stream byte accepted this edge |
| irq | output | 1 | Level interrupt request |
| dma_mode | output | 1 | Stored DMA-mode bit of FIFO control |
| rx_trig_lvl | output | 2 | Stored receive trigger level |

## Verification
- Timing of results:
  - A write updates state at the clock edge on which the strobe is sampled.
  - Read data is registered on that same edge, so it is valid one cycle after the strobe.
  - `irq`, `rx_ready`, `dma_mode` and `rx_trig_lvl` follow state combinationally, so they change in the cycle after the access.
- How the bench keeps to this: it drives every strobe for exactly one cycle from the falling edge. It samples read data, `irq` and `rx_ready` at the next falling edge, where each result is first due.
- Side effects: they are checked by a second read. The second read shows overrun, transmit-empty pending or the change bits already cleared.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  // Register offsets (16550-compatible map; decoded by host software)
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_IIR  = 3'd2;  // FIFO control on write
  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_MCR  = 3'd4;
  localparam logic [2:0] OFS_LSR  = 3'd5;
  localparam logic [2:0] OFS_MSR  = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  typedef enum logic [3:0] {
    IID_MODEM  = 4'h0,
    IID_NONE   = 4'h1,
    IID_THRE   = 4'h2,
    IID_RXDATA = 4'h4,
    IID_LINE   = 4'h6
  } iid_t;

  // Modem status nibble {DCD, RI, DSR, CTS} derived from modem control
  function automatic logic [3:0] modem_nibble(input logic [4:0] mcr);
    if (mcr[4]) modem_nibble = {mcr[3], mcr[2], mcr[0], mcr[1]};
    else        modem_nibble = 4'b1010;
  endfunction
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          deep,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic          pop,
  output logic [7:0]    pop_data,
  output logic          full,
  output logic          empty
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, cap;

  assign cap      = deep ? CW'(DEPTH) : CW'(1);
  assign full     = (count >= cap);
  assign empty    = (count == '0);
  assign pop_data = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  logic do_push, do_pop;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  // R11: occupancy never exceeds the selected capacity
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cap);
  // R10: a pop on a non-empty FIFO lowers the count unless a push coincides
  a_r10_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !push && !flush) |=> (count == $past(count) - CW'(1)));
endmodule

// File: rtl/uart_modem_stat.sv
module uart_modem_stat
  import uart_regbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] mcr_q,
  input  logic       mcr_wr,
  input  logic [4:0] mcr_new,
  input  logic       msr_rd,
  output logic [7:0] msr
);
  logic [3:0] delta_q;
  logic [3:0] cur_s, nxt_s;

  assign cur_s = modem_nibble(mcr_q);
  assign nxt_s = modem_nibble(mcr_new);
  assign msr   = {cur_s, delta_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delta_q <= '0;
    end else if (mcr_wr) begin
      delta_q[0] <= delta_q[0] | (cur_s[0] ^ nxt_s[0]);
      delta_q[1] <= delta_q[1] | (cur_s[1] ^ nxt_s[1]);
      delta_q[2] <= delta_q[2] | (cur_s[2] & ~nxt_s[2]);
      delta_q[3] <= delta_q[3] | (cur_s[3] ^ nxt_s[3]);
    end else if (msr_rd) begin
      delta_q <= '0;
    end
  end

  // R12: reading modem status clears the change bits
  a_r12_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && !mcr_wr) |=> (msr[3:0] == 4'h0));
  // R12: RI falling edge is recorded
  a_r12_ri_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (mcr_wr && cur_s[2] && !nxt_s[2]) |=> msr[2]);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_regbank_pkg::*;
(
  input  logic [3:0] ier,
  input  logic       line_evt,
  input  logic       rx_avail,
  input  logic       thre_pend,
  input  logic       modem_evt,
  output logic [3:0] iid,
  output logic       irq
);
  iid_t code;

  always_comb begin
    if (line_evt && ier[2])       code = IID_LINE;
    else if (rx_avail && ier[0])  code = IID_RXDATA;
    else if (thre_pend && ier[1]) code = IID_THRE;
    else if (modem_evt && ier[3]) code = IID_MODEM;
    else                          code = IID_NONE;
  end

  assign iid = code;
  assign irq = (code != IID_NONE);

  // R4: with every enable clear no interrupt can be raised
  always_comb begin
    a_r4_masked: assert (ier != 4'h0 || !irq);
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int REF_HZ = 1843200,
  parameter int BAUD   = 9600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       irq,
  output logic       dma_mode,
  output logic [1:0] rx_trig_lvl
);
  localparam int          DIV_INIT = REF_HZ / BAUD / 16;
  localparam logic [15:0] DIV_RST  = DIV_INIT[15:0];

  logic [7:0] div_lo, div_hi, lcr_q, scr_q, rdata_q;
  logic [3:0] ier_q;
  logic [4:0] mcr_q;
  logic       fcr_en, fcr_dma, oe_q, thre_q;
  logic [1:0] fcr_trig;

  logic dlab, loop;
  assign dlab = lcr_q[7];
  assign loop = mcr_q[4];

  // Access decode
  logic hit_div_lo, hit_div_hi, dl_sel;
  assign dl_sel     = dlab && (bus_addr == OFS_DATA || bus_addr == OFS_IER);
  assign hit_div_lo = dlab && bus_addr == OFS_DATA;
  assign hit_div_hi = dlab && bus_addr == OFS_IER;

  logic wr_data, wr_ier, wr_fcr, wr_lcr, wr_mcr, wr_scr;
  assign wr_data = bus_wr && !dl_sel && bus_addr == OFS_DATA;
  assign wr_ier  = bus_wr && !dl_sel && bus_addr == OFS_IER;
  assign wr_fcr  = bus_wr && bus_addr == OFS_IIR;
  assign wr_lcr  = bus_wr && bus_addr == OFS_LCR;
  assign wr_mcr  = bus_wr && bus_addr == OFS_MCR;
  assign wr_scr  = bus_wr && bus_addr == OFS_SCR;

  logic rd_data, rd_iir, rd_lsr, rd_msr;
  assign rd_data = bus_rd && !dl_sel && bus_addr == OFS_DATA;
  assign rd_iir  = bus_rd && bus_addr == OFS_IIR;
  assign rd_lsr  = bus_rd && bus_addr == OFS_LSR;
  assign rd_msr  = bus_rd && bus_addr == OFS_MSR;

  // Receive FIFO and its two sources
  logic       f_full, f_empty, f_push, f_pop, f_flush;
  logic [7:0] f_in, f_out;
  logic       lb_push, st_push;

  assign rx_ready = loop || !f_full;
  assign lb_push  = wr_data && loop;
  assign st_push  = rx_valid && !loop && !f_full;
  assign f_push   = (lb_push && !f_full) || st_push;
  assign f_in     = loop ? bus_wdata : rx_data;
  assign f_pop    = rd_data && !f_empty;
  assign f_flush  = wr_fcr && ((bus_wdata[0] != fcr_en) ||
                               (bus_wdata[0] && bus_wdata[1]));

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (f_flush),
    .deep      (fcr_en),
    .push      (f_push),
    .push_data (f_in),
    .pop       (f_pop),
    .pop_data  (f_out),
    .full      (f_full),
    .empty     (f_empty)
  );

  // Modem status
  logic [7:0] msr_v;
  uart_modem_stat u_modem (
    .clk     (clk),
    .rst_n   (rst_n),
    .mcr_q   (mcr_q),
    .mcr_wr  (wr_mcr),
    .mcr_new (bus_wdata[4:0]),
    .msr_rd  (rd_msr),
    .msr     (msr_v)
  );

  // Interrupt priority
  logic [3:0] iid;
  uart_irq_prio u_prio (
    .ier       (ier_q),
    .line_evt  (oe_q),
    .rx_avail  (!f_empty),
    .thre_pend (thre_q),
    .modem_evt (msr_v[3:0] != 4'h0),
    .iid       (iid),
    .irq       (irq)
  );

  // Register state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_lo   <= DIV_RST[7:0];
      div_hi   <= DIV_RST[15:8];
      ier_q    <= '0;
      lcr_q    <= '0;
      mcr_q    <= '0;
      scr_q    <= '0;
      fcr_en   <= 1'b0;
      fcr_dma  <= 1'b0;
      fcr_trig <= '0;
      oe_q     <= 1'b0;
      thre_q   <= 1'b0;
    end else begin
      if (bus_wr && hit_div_lo) div_lo <= bus_wdata;
      if (bus_wr && hit_div_hi) div_hi <= bus_wdata;
      if (wr_ier) ier_q <= bus_wdata[3:0];
      if (wr_lcr) lcr_q <= bus_wdata;
      if (wr_mcr) mcr_q <= bus_wdata[4:0];
      if (wr_scr) scr_q <= bus_wdata;
      if (wr_fcr) begin
        fcr_en   <= bus_wdata[0];
        fcr_dma  <= bus_wdata[0] & bus_wdata[3];
        fcr_trig <= bus_wdata[0] ? bus_wdata[7:6] : 2'b00;
      end
      if (lb_push && f_full) oe_q <= 1'b1;
      else if (rd_lsr)       oe_q <= 1'b0;
      if (wr_data)                          thre_q <= 1'b1;
      else if (rd_iir && iid == IID_THRE)   thre_q <= 1'b0;
    end
  end

  // Read data mux, registered
  logic [7:0] rd_mux;
  always_comb begin
    case (bus_addr)
      OFS_DATA: rd_mux = dlab ? div_lo : (f_empty ? 8'hFF : f_out);
      OFS_IER:  rd_mux = dlab ? div_hi : {4'h0, ier_q};
      OFS_IIR:  rd_mux = {fcr_en, fcr_en, 2'b00, iid};
      OFS_LCR:  rd_mux = lcr_q;
      OFS_MCR:  rd_mux = {3'b000, mcr_q};
      OFS_LSR:  rd_mux = {1'b0, 1'b1, 1'b1, 3'b000, oe_q, !f_empty};
      OFS_MSR:  rd_mux = msr_v;
      default:  rd_mux = scr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata   = rdata_q;
  assign dma_mode    = fcr_dma;
  assign rx_trig_lvl = fcr_trig;

  // R8: overrun is gone after a line-status read
  a_r8_oe_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !bus_wr) |=> !oe_q);
  // R6: data write leaves transmit-empty pending
  a_r6_thre_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> thre_q);
  // R3: only the low nibble of an IER write survives
  a_r3_ier_mask: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ier |=> (ier_q == $past(bus_wdata[3:0])));
  // R7: FIFO control write with enable clear leaves nothing stored
  a_r7_fcr_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fcr && !bus_wdata[0]) |=> (!fcr_en && !dma_mode && rx_trig_lvl == 2'b00));
  // R9: loopback write into a full FIFO raises overrun
  a_r9_lb_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_push && f_full) |=> oe_q);
endmodule

// File: tb/uart_regbank_test.sv
`timescale 1ns/1ps
module uart_regbank_test;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_ready, irq, dma_mode;
  logic [1:0] rx_trig_lvl;

  int n_cmp = 0, n_bad = 0;
  logic [4:0] b_mcr = '0;
  logic [3:0] b_delta = '0;

  always #2.5 clk = ~clk;

  uart_regbank #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .irq(irq), .dma_mode(dma_mode), .rx_trig_lvl(rx_trig_lvl)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  function automatic logic [3:0] nib(input logic [4:0] m);
    nib = m[4] ? {m[3], m[2], m[0], m[1]} : 4'b1010;
  endfunction

  // Bench model of MCR write effect on change bits
  task automatic wr_mcr(input logic [7:0] d);
    logic [3:0] o, n;
    o = nib(b_mcr);
    n = nib(d[4:0]);
    b_delta[0] |= o[0] ^ n[0];
    b_delta[1] |= o[1] ^ n[1];
    b_delta[2] |= o[2] & ~n[2];
    b_delta[3] |= o[3] ^ n[3];
    b_mcr = d[4:0];
    wr(3'd4, d);
  endtask

  task automatic rd_msr_chk(input string tag);
    rdchk(tag, 3'd6, {nib(b_mcr), b_delta});
    b_delta = '0;
  endtask

  function automatic logic [7:0] exp_iid(input logic [3:0] m);
    if (m[2])      exp_iid = 8'h06;
    else if (m[0]) exp_iid = 8'h04;
    else if (m[1]) exp_iid = 8'h02;
    else if (m[3]) exp_iid = 8'h00;
    else           exp_iid = 8'h01;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rx_ready", {7'd0, rx_ready}, 8'h01);
    rdchk("R1 IER", 3'd1, 8'h00);
    rdchk("R1 IIR", 3'd2, 8'h01);
    rdchk("R1 LCR", 3'd3, 8'h00);
    rdchk("R1 MCR", 3'd4, 8'h00);
    rdchk("R1 LSR", 3'd5, 8'h60);
    rdchk("R1 MSR", 3'd6, 8'hA0);
    rdchk("R1 SCR", 3'd7, 8'h00);
    wr(3'd3, 8'h80);
    rdchk("R1 div low", 3'd0, 8'h0C);
    rdchk("R1 div high", 3'd1, 8'h00);

    // R2: divisor access through LCR bit 7
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    rdchk("R2 div low", 3'd0, 8'h34);
    rdchk("R2 div high", 3'd1, 8'h12);
    wr(3'd3, 8'h03);
    rdchk("R2 LCR", 3'd3, 8'h03);
    rdchk("R2 IER untouched", 3'd1, 8'h00);
    rdchk("R10 empty data", 3'd0, 8'hFF);
    wr(3'd3, 8'h83);
    rdchk("R2 div kept", 3'd0, 8'h34);
    wr(3'd3, 8'h03);

    // R3: IER mask, all byte values
    for (int i = 0; i < 256; i++) begin
      wr(3'd1, 8'(i));
      rdchk("R3 IER", 3'd1, 8'(i) & 8'h0F);
    end
    wr(3'd1, 8'h00);

    // R13: scratch and ignored LSR/MSR writes
    for (int i = 0; i < 256; i++) begin
      wr(3'd7, 8'(i));
      rdchk("R13 SCR", 3'd7, 8'(i));
      if (i % 17 == 0) begin
        wr(3'd5, 8'(i));
        rdchk("R13 LSR write ignored", 3'd5, 8'h60);
        wr(3'd6, 8'(i));
        rdchk("R13 MSR write ignored", 3'd6, 8'hA0);
      end
    end

    // R12: every MCR value, modem status and change bits
    for (int m = 0; m < 32; m++) begin
      wr_mcr(8'hE0 | 8'(m));
      rdchk("R12 MCR", 3'd4, 8'(m));
      rd_msr_chk("R12 MSR");
      rd_msr_chk("R12 MSR after clear");
    end
    wr_mcr(8'h00);
    rd_msr_chk("R12 MSR back");

    // R6: transmit-empty pending
    wr(3'd1, 8'h02);
    @(negedge clk);
    chk("R6 idle irq", {7'd0, irq}, 8'h00);
    wr(3'd0, 8'h55);
    chk("R14 irq thre", {7'd0, irq}, 8'h01);
    rdchk("R6 IIR thre", 3'd2, 8'h02);
    chk("R14 irq after ack", {7'd0, irq}, 8'h00);
    rdchk("R6 IIR cleared", 3'd2, 8'h01);
    wr(3'd1, 8'h00);

    // R4/R14: all causes active, sweep the enable nibble
    wr_mcr(8'h10);
    wr(3'd0, 8'hA5);
    wr(3'd0, 8'h5A);
    chk("R11 loopback ready", {7'd0, rx_ready}, 8'h01);
    for (int m = 0; m < 16; m++) begin
      wr(3'd1, 8'(m));
      chk("R14 irq level", {7'd0, irq}, (m != 0) ? 8'h01 : 8'h00);
      rdchk("R4 IIR priority", 3'd2, exp_iid(4'(m)));
      wr(3'd0, 8'h77);
    end
    rdchk("R8 LSR overrun", 3'd5, 8'h63);
    rdchk("R8 LSR cleared", 3'd5, 8'h61);
    rdchk("R4 IIR rx", 3'd2, 8'h04);
    rdchk("R9 loopback byte", 3'd0, 8'hA5);
    rdchk("R6 IIR thre", 3'd2, 8'h02);
    rdchk("R4 IIR modem", 3'd2, 8'h00);
    rd_msr_chk("R12 MSR loop");
    rdchk("R4 IIR none", 3'd2, 8'h01);
    chk("R14 irq low", {7'd0, irq}, 8'h00);
    wr(3'd1, 8'h00);

    // R5/R7/R9/R10: FIFO mode in loopback
    wr(3'd2, 8'h01);
    rdchk("R5 IIR fifo", 3'd2, 8'hC1);
    for (int i = 0; i < DEPTH + 1; i++) wr(3'd0, 8'(i * 37 + 3));
    rdchk("R9 LSR full overrun", 3'd5, 8'h63);
    for (int i = 0; i < DEPTH; i++) rdchk("R10 fifo order", 3'd0, 8'(i * 37 + 3));
    rdchk("R10 empty", 3'd0, 8'hFF);
    rdchk("R8 LSR idle", 3'd5, 8'h60);
    wr(3'd0, 8'h11);
    wr(3'd0, 8'h22);
    wr(3'd2, 8'h03);
    rdchk("R7 flush", 3'd5, 8'h60);
    wr(3'd0, 8'h33);
    wr(3'd2, 8'h00);
    rdchk("R7 disable flush", 3'd5, 8'h60);
    rdchk("R5 IIR plain", 3'd2, 8'h01);
    wr(3'd2, 8'hFF);
    @(negedge clk);
    chk("R7 stored bits", {5'd0, dma_mode, rx_trig_lvl}, 8'h07);
    rdchk("R5 IIR fifo again", 3'd2, 8'hC1);
    wr(3'd2, 8'hFE);
    @(negedge clk);
    chk("R7 zero store", {5'd0, dma_mode, rx_trig_lvl}, 8'h00);

    // R11: receive stream with back-pressure
    wr_mcr(8'h00);
    rd_msr_chk("R12 MSR exit loop");
    wr(3'd2, 8'h01);
    for (int i = 0; i < DEPTH + 2; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'(200 + i);
      #0.1;
      chk("R11 ready", {7'd0, rx_ready}, (i < DEPTH) ? 8'h01 : 8'h00);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++) rdchk("R11 stream data", 3'd0, 8'(200 + i));
    wr(3'd2, 8'h00);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h9C;
    @(negedge clk);
    chk("R11 depth one full", {7'd0, rx_ready}, 8'h00);
    rx_valid = 1'b0;
    rdchk("R11 depth one data", 3'd0, 8'h9C);
    chk("R11 ready again", {7'd0, rx_ready}, 8'h01);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule